// File: doc/BRIEF.md
# Latched Priority Interrupt Controller

This block sits beside a small processor sequencer and decides which interrupt to service next. It keeps a 32-bit pending register and a 32-bit enable register. Bits in the pending register are set by hardware event pulses, by a timer-expiry pulse, by level-held arithmetic exception flags, and by software writes. The block presents the winning pending, enabled source as a valid flag and a 5-bit vector index. When the sequencer accepts that source, the block clears its pending bit. It then presents nothing more until the sequencer signals a return from interrupt.

One timer expiry sets two pending bits, one at a high-priority position and one at a low-priority position. Software picks the priority it wants by enabling only one of them. Arithmetic exception sources follow their sticky flags rather than edges. If software leaves a sticky flag set, the same interrupt comes back after the return. Flags from the secondary processing element count only while SIMD mode is on.

Top module: `irqc_top`

## Requirements
- R1: After reset the pending register and the enable register both read 0 and `irqValid` is low.
- R2: A one-cycle `timerZero` pulse sets pending bit 3 and pending bit 20 on the same clock edge.
- R3: If bits 3 and 20 are both pending and enabled, bit 3 is presented and serviced first. Bit 20 stays pending and is presented after the return, as a separate service.
- R4: A register write to address 0 loads the pending register. The software request bits 24 to 27 set this way are arbitrated and serviced in index order like any other source.
- R5: While `stickyX[k]` is high, pending bit 8+k is set on every clock edge (k = 0..2). As a result the source is presented again after each return until the flag drops.
- R6: `stickyY[k]` sets pending bit 8+k only while `simdMode` is high. With `simdMode` low it changes neither the pending register nor `irqValid`.
- R7: `irqVector` is the lowest index i for which pending[i] and enable[i] are both 1. `irqValid` is high only when such an i exists and no service is in progress.
- R8: `irqAccept` while `irqValid` is high clears the presented pending bit on that edge. `irqValid` then stays low until an `rtiPulse`.
- R9: If a hardware set and a software write of 0 reach the same pending bit in the same cycle, the bit ends up 1.
- R10: A write to address 1 loads the enable register, and arbitration uses the new value from the next cycle on. A disabled source stays pending and readable at address 0.
- R11: A pulse on `hwEvent[i]` sets pending bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 pending, 1 enable |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected register |
| hwEvent | input | 32 | Hardware event pulses, one per pending bit |
| timerZero | input | 1 | Timer reached-zero pulse |
| stickyX | input | 3 | Primary-element sticky exception flags |
| stickyY | input | 3 | Secondary-element sticky exception flags |
| simdMode | input | 1 | Enables the secondary flags |
| irqValid | output | 1 | An interrupt is being presented |
| irqVector | output | 5 | Index of the presented interrupt |
| irqAccept | input | 1 | Sequencer takes the presented interrupt |
| rtiPulse | input | 1 | Return from interrupt; ends service |

## Verification
A wrong pending bit shows up in the register read on the cycle after the edge that produced it. It also shows up in `irqVector` as soon as it is the winning enabled bit. A stuck or missing service flag shows up right after an accept or a return, as `irqValid` asserting too early or never coming back. The bench sweeps every single source and every ordered pair of sources. This exposes a wrong priority order or a wrong clear position within one service.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef struct packed {
    logic latchWr;
    logic maskWr;
    logic accept;
  } irqcStrobes_t;
endpackage

// File: rtl/irqc_sources.sv
module irqc_sources #(
  parameter int N = 32,
  parameter int S = 3,
  parameter int TIMER_HI = 3,
  parameter int TIMER_LO = 20,
  parameter int ARITH_BASE = 8
) (
  input  logic [N-1:0] hwEvent,
  input  logic         timerZero,
  input  logic [S-1:0] stickyX,
  input  logic [S-1:0] stickyY,
  input  logic         simdMode,
  output logic [N-1:0] setVec
);
  logic [S-1:0] arithLevel;

  // Secondary flags are gated by SIMD mode, one gate per exception kind
  for (genvar k = 0; k < S; k++) begin : g_arith
    assign arithLevel[k] = stickyX[k] | (simdMode & stickyY[k]);
  end

  always_comb begin
    setVec = hwEvent;
    if (timerZero) begin
      setVec[TIMER_HI] = 1'b1;
      setVec[TIMER_LO] = 1'b1;
    end
    for (int k = 0; k < S; k++) begin
      setVec[ARITH_BASE + k] = setVec[ARITH_BASE + k] | arithLevel[k];
    end
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int N = 32,
  localparam int VW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  irqcStrobes_t  strobes,
  input  logic [N-1:0]  wrData,
  input  logic [N-1:0]  setVec,
  output logic [N-1:0]  latchQ,
  output logic [N-1:0]  maskQ,
  output logic          anyPending,
  output logic [VW-1:0] topVector
);
  logic [N-1:0] eligible;
  logic [N-1:0] ackClr;
  logic [N-1:0] latchNext;

  assign eligible   = latchQ & maskQ;
  assign anyPending = |eligible;

  // Fixed priority: lowest index wins, so scan from the top down
  always_comb begin
    topVector = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eligible[i]) topVector = VW'(i);
    end
  end

  always_comb begin
    ackClr = '0;
    if (strobes.accept) ackClr[topVector] = 1'b1;
  end

  // Hardware sets are ORed in last, so they win over writes and clears
  always_comb begin
    if (strobes.latchWr) latchNext = wrData | setVec;
    else                 latchNext = (latchQ & ~ackClr) | setVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ <= '0;
      maskQ  <= '0;
    end else begin
      latchQ <= latchNext;
      if (strobes.maskWr) maskQ <= wrData;
    end
  end
endmodule

// File: rtl/irqc_control.sv
module irqc_control
  import irqc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic         regAddr,
  input  logic         irqAccept,
  input  logic         rtiPulse,
  input  logic         anyPending,
  output irqcStrobes_t strobes,
  output logic         irqValid
);
  logic inService;

  assign irqValid = anyPending & ~inService;

  always_comb begin
    strobes.latchWr = regWrEn & ~regAddr;
    strobes.maskWr  = regWrEn & regAddr;
    strobes.accept  = irqAccept & irqValid;
  end

  // No nesting: one service at a time, ended only by a return pulse
  always_ff @(posedge clk) begin
    if (!rstN)               inService <= 1'b0;
    else if (strobes.accept) inService <= 1'b1;
    else if (rtiPulse)       inService <= 1'b0;
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int N = 32,
  parameter int S = 3,
  parameter int TIMER_HI = 3,
  parameter int TIMER_LO = 20,
  parameter int ARITH_BASE = 8,
  localparam int VW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic          regAddr,
  input  logic [N-1:0]  regWrData,
  output logic [N-1:0]  regRdData,
  input  logic [N-1:0]  hwEvent,
  input  logic          timerZero,
  input  logic [S-1:0]  stickyX,
  input  logic [S-1:0]  stickyY,
  input  logic          simdMode,
  output logic          irqValid,
  output logic [VW-1:0] irqVector,
  input  logic          irqAccept,
  input  logic          rtiPulse
);
  irqcStrobes_t strobes;
  logic [N-1:0] setVec;
  logic [N-1:0] latchQ;
  logic [N-1:0] maskQ;
  logic         anyPending;

  irqc_sources #(
    .N(N), .S(S), .TIMER_HI(TIMER_HI), .TIMER_LO(TIMER_LO), .ARITH_BASE(ARITH_BASE)
  ) u_src (
    .hwEvent(hwEvent), .timerZero(timerZero), .stickyX(stickyX),
    .stickyY(stickyY), .simdMode(simdMode), .setVec(setVec)
  );

  irqc_control u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .irqAccept(irqAccept), .rtiPulse(rtiPulse), .anyPending(anyPending),
    .strobes(strobes), .irqValid(irqValid)
  );

  irqc_datapath #(.N(N)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWrData),
    .setVec(setVec), .latchQ(latchQ), .maskQ(maskQ),
    .anyPending(anyPending), .topVector(irqVector)
  );

  assign regRdData = regAddr ? maskQ : latchQ;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N = 32,
  parameter int S = 3,
  parameter int TIMER_HI = 3,
  parameter int TIMER_LO = 20,
  parameter int ARITH_BASE = 8,
  localparam int VW = $clog2(N)
) (
  input logic          clk,
  input logic          rstN,
  input logic          regWrEn,
  input logic          regAddr,
  input logic          timerZero,
  input logic [S-1:0]  stickyX,
  input logic          irqValid,
  input logic [VW-1:0] irqVector,
  input logic          irqAccept,
  input logic          rtiPulse,
  input logic [N-1:0]  latchQ,
  input logic [N-1:0]  maskQ
);
  a_r2_timer_sets_both: assert property (@(posedge clk) disable iff (!rstN)
    timerZero |=> (latchQ[TIMER_HI] && latchQ[TIMER_LO]));

  a_r9_set_beats_write: assert property (@(posedge clk) disable iff (!rstN)
    (timerZero && regWrEn && !regAddr) |=> latchQ[TIMER_HI]);

  a_r5_sticky_relatches: assert property (@(posedge clk) disable iff (!rstN)
    stickyX[0] |=> latchQ[ARITH_BASE]);

  a_r7_vector_eligible: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (latchQ[irqVector] && maskQ[irqVector]));

  a_r8_quiet_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && irqAccept) |=> !irqValid);

  a_r8_quiet_until_rti: assert property (@(posedge clk) disable iff (!rstN)
    (!irqValid && $past(irqValid && irqAccept) && !rtiPulse) |=> !irqValid);
endmodule

bind irqc_top irqc_checker #(
  .N(N), .S(S), .TIMER_HI(TIMER_HI), .TIMER_LO(TIMER_LO), .ARITH_BASE(ARITH_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .timerZero(timerZero), .stickyX(stickyX), .irqValid(irqValid),
  .irqVector(irqVector), .irqAccept(irqAccept), .rtiPulse(rtiPulse),
  .latchQ(latchQ), .maskQ(maskQ)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] hwEvent = '0;
  logic        timerZero = 1'b0;
  logic [2:0]  stickyX = '0;
  logic [2:0]  stickyY = '0;
  logic        simdMode = 1'b0;
  logic        irqValid;
  logic [4:0]  irqVector;
  logic        irqAccept = 1'b0;
  logic        rtiPulse = 1'b0;

  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irqc_top u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] v);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic acceptOne();
    irqAccept = 1'b1; step(); irqAccept = 1'b0;
  endtask

  task automatic rti();
    rtiPulse = 1'b1; step(); rtiPulse = 1'b0;
  endtask

  task automatic expectIrq(input string req, input int vec);
    chk(req, {31'd0, irqValid}, 32'd1);
    chk(req, {27'd0, irqVector}, vec);
  endtask

  initial begin
    logic [31:0] v;
    step(); step();
    rstN = 1'b1;
    step();

    // R1 reset state
    rd(0, v); chk("R1 latch", v, 0);
    rd(1, v); chk("R1 mask", v, 0);
    chk("R1 valid", {31'd0, irqValid}, 0);

    // R10 masked source stays pending
    wr(0, 32'h20);
    chk("R10 masked no valid", {31'd0, irqValid}, 0);
    rd(0, v); chk("R10 still pending", v, 32'h20);
    wr(1, 32'h20);
    expectIrq("R10 unmask next cycle", 5);
    wr(0, 32'h84); wr(1, 32'h80);
    expectIrq("R10 R7 masked higher bit", 7);
    wr(0, 0);
    wr(1, 32'hFFFF_FFFF);

    // R7 R8 single source sweep
    for (int i = 0; i < 32; i++) begin
      wr(0, 32'd1 << i);
      expectIrq("R7 single", i);
      acceptOne();
      rd(0, v); chk("R8 cleared", v, 0);
      chk("R8 quiet", {31'd0, irqValid}, 0);
      rti();
      chk("R8 idle after rti", {31'd0, irqValid}, 0);
    end

    // R7 pair sweep: lower index wins
    for (int i = 0; i < 32; i++) begin
      for (int j = i + 1; j < 32; j++) begin
        wr(0, (32'd1 << i) | (32'd1 << j));
        expectIrq("R7 pair", i);
        acceptOne();
        rd(0, v); chk("R8 pair clear", v, 32'd1 << j);
        rti();
        expectIrq("R7 pair second", j);
        wr(0, 0);
      end
    end

    // R2 R3 timer
    timerZero = 1'b1; step(); timerZero = 1'b0;
    rd(0, v); chk("R2 both bits", v, (32'd1 << 3) | (32'd1 << 20));
    expectIrq("R3 high first", 3);
    acceptOne();
    rd(0, v); chk("R3 low remains", v, 32'd1 << 20);
    chk("R3 no nest", {31'd0, irqValid}, 0);
    rti();
    expectIrq("R3 low second", 20);
    acceptOne(); rti();
    chk("R3 done", {31'd0, irqValid}, 0);

    // R9 hardware set beats software clear
    regWrEn = 1'b1; regAddr = 1'b0; regWrData = 0; timerZero = 1'b1;
    step();
    regWrEn = 1'b0; timerZero = 1'b0;
    rd(0, v); chk("R9 set wins", v, (32'd1 << 3) | (32'd1 << 20));
    wr(0, 0);

    // R4 software request bits
    wr(0, 32'hF << 24);
    for (int i = 24; i < 28; i++) begin
      expectIrq("R4 soft order", i);
      acceptOne(); rti();
    end
    chk("R4 all served", {31'd0, irqValid}, 0);

    // R11 hardware event
    hwEvent[17] = 1'b1; step(); hwEvent = '0;
    rd(0, v); chk("R11 event bit", v, 32'd1 << 17);
    expectIrq("R11 vector", 17);
    acceptOne(); rti();

    // R5 sticky re-assert
    stickyX[1] = 1'b1; step();
    expectIrq("R5 sticky", 9);
    acceptOne();
    chk("R5 quiet in service", {31'd0, irqValid}, 0);
    rti();
    expectIrq("R5 again after rti", 9);
    stickyX = '0;
    acceptOne(); rti();
    chk("R5 gone after clear", {31'd0, irqValid}, 0);
    rd(0, v); chk("R5 latch empty", v, 0);

    // R6 secondary flags gated by SIMD mode
    stickyY[2] = 1'b1; step(); step();
    rd(0, v); chk("R6 ignored no simd", v, 0);
    chk("R6 no valid", {31'd0, irqValid}, 0);
    simdMode = 1'b1; step();
    expectIrq("R6 simd on", 10);
    stickyY = '0; simdMode = 1'b0;
    acceptOne(); rti();
    chk("R6 done", {31'd0, irqValid}, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nTests++; nFail++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule